// File: doc/BRIEF.md
# Calendar Time Counter With Snapshot

This block keeps wall-clock time and date in a chain of plain binary counters: hundredths of a second, seconds, minutes, hours, day of month, month, two-digit year and day of week. A fractional prescaler turns pulses of a reference clock into a 100 Hz advance strobe. Four reference rates can be selected, and the average rate stays exact even when the reference frequency is not a multiple of 100.

Software reaches the counters and a small command register over an 8-bit register bus with chip select, read and write strobes and a five-bit address. The address can be presented directly, with the latch strobe held high, or it can be captured from a multiplexed bus when the strobe falls. Reading the hundredths counter freezes a copy of every other counter. Later reads of the other counters return that copy, so a read that spans several registers always sees one instant in time.

Top module: `rtc_calendar`

## Requirements
- R1: Register addresses: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day of month, 5 month, 6 year, 7 day of week. When run is set, each 100 Hz strobe advances hundredths 0..99, and a carry ripples into seconds 0..59, minutes 0..59 and hours 0..23. A counter only changes on a strobe or on a write to it. A write is stored on the clock edge that samples it.
- R2: With frequency select k (0: 32768 Hz, 1: 1048576 Hz, 2: 2097152 Hz, 3: 4194304 Hz), the prescaler adds 100 per reference pulse and strobes when the sum reaches the selected rate. After a restart, the first strobe comes on reference pulse ceil(F/100), and hundredths changes on the next clock edge.
- R3: Reading address 0 returns the live hundredths and copies all counters into a snapshot. Reads of addresses 1..7 return the snapshot, which changes only on the next address-0 read.
- R4: Year counts 0..99 and wraps to 0 when 31 December ends.
- R5: Command bit 2 clear selects 12-hour format. In that format, the hours byte is 1..12 in bits [4:0], with bit 7 set for PM. Midnight reads 0x0C, noon reads 0x8C, and writes use the same encoding. Command bit 2 set selects 24-hour format, 0..23.
- R6: February ends after day 29 when year mod 4 is 0, and after day 28 otherwise.
- R7: The command register sits at address 0x11: bits [1:0] frequency select, bit 2 24-hour format, bit 3 run, bit 4 interrupt enable. It reads back as {3'b000, bits}. After reset it is 0, hundredths through hours are 0, day and month are 1, and year and weekday are 0.
- R8: While the latch strobe is high, the address inputs are used directly. After it falls, the address seen on the last clock edge with the strobe high is used.
- R9: While power-down is high, bus writes, reads and snapshot loads are ignored, so the read data holds. Counting continues.
- R10: With run clear, neither the prescaler nor the counters advance.
- R11: Writing hundredths restarts the prescaler phase. A strobe that coincides with any other counter write is applied on the following cycle.
- R12: Day of week counts 0..6, advances at every midnight and wraps from 6 to 0.
- R13: April, June, September and November end after day 30, and the other months except February after day 31. The day then returns to 1 and the month advances, wrapping 12 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | One pulse per reference-oscillator period |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| ale | input | 1 | Address latch strobe; high means direct address |
| pwr_down | input | 1 | Power-down; blocks bus access |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
The counter chain is tried from randomly chosen instants that are biased toward the last value of each field, so that carries stop at different depths and unrelated fields are shown to hold. Directed instants cover the month ends of leap and common years, the end of the century and weekday 6, and the noon and midnight crossings in 12-hour format, which separate the day-length and hour-encoding paths. Exact-cycle reads after a prescaler restart, at two frequency selects, tell an off-by-one phase apart from a correct one. Writes made while the snapshot is frozen, accesses during power-down, and multiplexed addressing with a misleading address left on the bus separate the live path from the snapshot and latched paths.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

  localparam logic [4:0] A_HUND  = 5'd0;
  localparam logic [4:0] A_SEC   = 5'd1;
  localparam logic [4:0] A_MIN   = 5'd2;
  localparam logic [4:0] A_HOUR  = 5'd3;
  localparam logic [4:0] A_DATE  = 5'd4;
  localparam logic [4:0] A_MONTH = 5'd5;
  localparam logic [4:0] A_YEAR  = 5'd6;
  localparam logic [4:0] A_WDAY  = 5'd7;
  localparam logic [4:0] A_CMD   = 5'h11;
  localparam int         N_FIELDS = 8;

  typedef struct packed {
    logic [6:0] hund;
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hour;
    logic [4:0] date;
    logic [3:0] month;
    logic [6:0] year;
    logic [2:0] wday;
  } rtc_time_t;

  typedef struct packed {
    logic       irq_en;
    logic       run;
    logic       h24;
    logic [1:0] fsel;
  } rtc_cmd_t;

  function automatic logic [4:0] days_of(input logic [3:0] m, input logic [6:0] y);
    case (m)
      4'd4, 4'd6, 4'd9, 4'd11: days_of = 5'd30;
      4'd2:    days_of = (y[1:0] == 2'd0) ? 5'd29 : 5'd28;
      default: days_of = 5'd31;
    endcase
  endfunction

  // internal 0..23 -> bus byte in the selected format
  function automatic logic [7:0] hour_to_bus(input logic [4:0] h, input logic h24);
    if (h24)            hour_to_bus = {3'b000, h};
    else if (h == 5'd0) hour_to_bus = 8'h0C;
    else if (h < 5'd12) hour_to_bus = {3'b000, h};
    else if (h == 5'd12) hour_to_bus = 8'h8C;
    else                hour_to_bus = {3'b100, h - 5'd12};
  endfunction

  // bus byte in the selected format -> internal 0..23
  function automatic logic [4:0] bus_to_hour(input logic [7:0] v, input logic h24);
    if (h24)                 bus_to_hour = v[4:0];
    else if (v[4:0] == 5'd12) bus_to_hour = v[7] ? 5'd12 : 5'd0;
    else                     bus_to_hour = v[4:0] + (v[7] ? 5'd12 : 5'd0);
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int unsigned REF_HZ0 = 32768,
  parameter int unsigned REF_HZ1 = 1048576,
  parameter int unsigned REF_HZ2 = 2097152,
  parameter int unsigned REF_HZ3 = 4194304,
  parameter int unsigned TICK_HZ = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       enable,
  input  logic       ref_en,
  input  logic [1:0] fsel,
  output logic       tick
);
  localparam int unsigned MAX01  = (REF_HZ0 > REF_HZ1) ? REF_HZ0 : REF_HZ1;
  localparam int unsigned MAX23  = (REF_HZ2 > REF_HZ3) ? REF_HZ2 : REF_HZ3;
  localparam int unsigned MAX_HZ = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int          ACC_W  = $clog2(MAX_HZ + TICK_HZ) + 1;

  logic [ACC_W-1:0] acc, limit, sum;

  always_comb begin
    case (fsel)
      2'd0:    limit = ACC_W'(REF_HZ0);
      2'd1:    limit = ACC_W'(REF_HZ1);
      2'd2:    limit = ACC_W'(REF_HZ2);
      default: limit = ACC_W'(REF_HZ3);
    endcase
    sum = acc + ACC_W'(TICK_HZ);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      acc  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (enable && ref_en) begin
        if (sum >= limit) begin
          acc  <= sum - limit;
          tick <= 1'b1;
        end else begin
          acc  <= sum;
        end
      end
    end
  end

  // R2 / R10: a strobe only follows an enabled reference pulse
  assert_tick_needs_ref_R2: assert property (@(posedge clk) disable iff (rst)
    tick |-> ($past(ref_en) && $past(enable)));
  assert_stopped_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (!enable && !restart) |=> !tick);

endmodule

// File: rtl/rtc_time_chain.sv
`timescale 1ns/1ps
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       adv,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [6:0] wr_val,
  output rtc_time_t  now
);
  rtc_time_t cur, nxt;
  logic c_hund, c_sec, c_min, c_hour, c_date, c_month;

  assign now = cur;

  always_comb begin
    c_hund  = cur.hund >= 7'd99;
    c_sec   = c_hund && (cur.sec >= 6'd59);
    c_min   = c_sec && (cur.min >= 6'd59);
    c_hour  = c_min && (cur.hour >= 5'd23);
    c_date  = c_hour && (cur.date >= days_of(cur.month, cur.year));
    c_month = c_date && (cur.month >= 4'd12);

    nxt = cur;
    if (wr_en) begin
      case (wr_sel)
        3'd0: nxt.hund  = wr_val;
        3'd1: nxt.sec   = wr_val[5:0];
        3'd2: nxt.min   = wr_val[5:0];
        3'd3: nxt.hour  = wr_val[4:0];
        3'd4: nxt.date  = wr_val[4:0];
        3'd5: nxt.month = wr_val[3:0];
        3'd6: nxt.year  = wr_val;
        default: nxt.wday = wr_val[2:0];
      endcase
    end else if (adv) begin
      nxt.hund = c_hund ? 7'd0 : cur.hund + 7'd1;
      if (c_hund) nxt.sec = c_sec ? 6'd0 : cur.sec + 6'd1;
      if (c_sec)  nxt.min = c_min ? 6'd0 : cur.min + 6'd1;
      if (c_min)  nxt.hour = c_hour ? 5'd0 : cur.hour + 5'd1;
      if (c_hour) begin
        nxt.date = c_date ? 5'd1 : cur.date + 5'd1;
        nxt.wday = (cur.wday >= 3'd6) ? 3'd0 : cur.wday + 3'd1;
      end
      if (c_date)  nxt.month = c_month ? 4'd1 : cur.month + 4'd1;
      if (c_month) nxt.year  = (cur.year >= 7'd99) ? 7'd0 : cur.year + 7'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur       <= '0;
      cur.date  <= 5'd1;
      cur.month <= 4'd1;
    end else begin
      cur <= nxt;
    end
  end

  // R1: counters hold unless strobed or written
  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (!adv && !wr_en) |=> $stable(cur));
  // R1: seconds move only on a hundredths wrap
  assert_sec_carry_R1: assert property (@(posedge clk) disable iff (rst)
    (adv && !wr_en && cur.hund != 7'd99) |=> $stable(cur.sec));
  // R4 / R13: end of year
  assert_year_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (adv && !wr_en && cur.hund == 7'd99 && cur.sec == 6'd59 && cur.min == 6'd59 &&
     cur.hour == 5'd23 && cur.date == 5'd31 && cur.month == 4'd12 && cur.year == 7'd99)
    |=> (cur.year == 7'd0 && cur.month == 4'd1 && cur.date == 5'd1));
  // R6: leap-year February continues to day 29
  assert_leap_day_R6: assert property (@(posedge clk) disable iff (rst)
    (adv && !wr_en && cur.hund == 7'd99 && cur.sec == 6'd59 && cur.min == 6'd59 &&
     cur.hour == 5'd23 && cur.date == 5'd28 && cur.month == 4'd2 && cur.year[1:0] == 2'd0)
    |=> (cur.date == 5'd29));
  // R12: weekday wraps at midnight
  assert_wday_wrap_R12: assert property (@(posedge clk) disable iff (rst)
    (adv && !wr_en && cur.hund == 7'd99 && cur.sec == 6'd59 && cur.min == 6'd59 &&
     cur.hour == 5'd23 && cur.wday == 3'd6) |=> (cur.wday == 3'd0));

endmodule

// File: rtl/rtc_bus_port.sv
`timescale 1ns/1ps
module rtc_bus_port
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic              ale,
  input  logic              pwr_down,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  rtc_time_t         live,
  output logic              t_wr_en,
  output logic [2:0]        t_wr_sel,
  output logic [6:0]        t_wr_val,
  output rtc_cmd_t          cmd,
  output logic [7:0]        rdata
);
  localparam int IDX_W = $clog2(N_FIELDS);

  logic [ADDR_W-1:0]              addr_q, eff;
  logic [N_FIELDS-1:0][7:0]       live_b, snap;
  logic                           rd_go, wr_go, time_hit, cmd_hit, capture;
  logic [IDX_W-1:0]               idx;
  logic [7:0]                     snap_val;

  always_comb begin
    eff      = ale ? addr : addr_q;
    idx      = eff[IDX_W-1:0];
    time_hit = (eff < ADDR_W'(N_FIELDS));
    cmd_hit  = (eff == ADDR_W'(A_CMD));
    rd_go    = cs && rd && !pwr_down;
    wr_go    = cs && wr && !pwr_down;
    capture  = rd_go && (eff == ADDR_W'(A_HUND));

    live_b[0] = {1'b0, live.hund};
    live_b[1] = {2'b00, live.sec};
    live_b[2] = {2'b00, live.min};
    live_b[3] = {3'b000, live.hour};
    live_b[4] = {3'b000, live.date};
    live_b[5] = {4'b0000, live.month};
    live_b[6] = {1'b0, live.year};
    live_b[7] = {5'b00000, live.wday};

    t_wr_en  = wr_go && time_hit;
    t_wr_sel = idx;
    t_wr_val = (idx == IDX_W'(A_HOUR)) ? {2'b00, bus_to_hour(wdata, cmd.h24)} : wdata[6:0];

    snap_val = (idx == IDX_W'(A_HOUR)) ? hour_to_bus(snap[A_HOUR][4:0], cmd.h24) : snap[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      snap   <= '0;
      cmd    <= '0;
      rdata  <= '0;
    end else begin
      if (ale) addr_q <= addr;
      if (capture) snap <= live_b;
      if (wr_go && cmd_hit) cmd <= wdata[4:0];
      if (rd_go) begin
        if (capture)       rdata <= live_b[0];
        else if (time_hit) rdata <= snap_val;
        else if (cmd_hit)  rdata <= {3'b000, cmd};
        else               rdata <= 8'h00;
      end
    end
  end

  // R3: snapshot only reloads on a hundredths read
  assert_snap_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(snap));
  // R9: power-down freezes read data and command
  assert_pd_rdata_R9: assert property (@(posedge clk) disable iff (rst)
    pwr_down |=> $stable(rdata));
  assert_pd_cmd_R9: assert property (@(posedge clk) disable iff (rst)
    pwr_down |=> $stable(cmd));

endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int          ADDR_W  = 5,
  parameter int unsigned REF_HZ0 = 32768,
  parameter int unsigned REF_HZ1 = 1048576,
  parameter int unsigned REF_HZ2 = 2097152,
  parameter int unsigned REF_HZ3 = 4194304,
  parameter int unsigned TICK_HZ = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_en,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic              ale,
  input  logic              pwr_down,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  rtc_time_t  now;
  rtc_cmd_t   cmd;
  logic       t_wr_en, restart, tick, pend, adv;
  logic [2:0] t_wr_sel;
  logic [6:0] t_wr_val;

  assign restart = t_wr_en && (t_wr_sel == 3'd0);
  assign adv     = (tick || pend) && !t_wr_en;

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= (tick || pend) && t_wr_en && !restart;
  end

  rtc_bus_port #(.ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .ale(ale),
    .pwr_down(pwr_down), .addr(addr), .wdata(wdata), .live(now),
    .t_wr_en(t_wr_en), .t_wr_sel(t_wr_sel), .t_wr_val(t_wr_val),
    .cmd(cmd), .rdata(rdata)
  );

  rtc_prescaler #(
    .REF_HZ0(REF_HZ0), .REF_HZ1(REF_HZ1), .REF_HZ2(REF_HZ2),
    .REF_HZ3(REF_HZ3), .TICK_HZ(TICK_HZ)
  ) u_pre (
    .clk(clk), .rst(rst), .restart(restart), .enable(cmd.run),
    .ref_en(ref_en), .fsel(cmd.fsel), .tick(tick)
  );

  rtc_time_chain u_chain (
    .clk(clk), .rst(rst), .adv(adv), .wr_en(t_wr_en),
    .wr_sel(t_wr_sel), .wr_val(t_wr_val), .now(now)
  );

  // R11: a strobe blocked by a non-hundredths write is kept for the next cycle
  assert_deferred_tick_R11: assert property (@(posedge clk) disable iff (rst)
    (tick && t_wr_en && !restart) |=> pend);

endmodule

// File: tb/test_rtc_calendar.sv
`timescale 1ns/1ps
module test_rtc_calendar;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_en = 1'b1;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0, ale = 1'b1, pwr_down = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rtc_calendar i_rtc_calendar (
    .clk(clk), .rst(rst), .ref_en(ref_en), .cs(cs), .rd(rd), .wr(wr),
    .ale(ale), .pwr_down(pwr_down), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  typedef struct packed { int h; int s; int m; int hr; int d; int mo; int y; int w; } tm_t;

  function automatic int mdays(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic tm_t tnext(tm_t t);
    tm_t r = t;
    r.h = t.h + 1;
    if (r.h < 100) return r;
    r.h = 0; r.s = t.s + 1;
    if (r.s < 60) return r;
    r.s = 0; r.m = t.m + 1;
    if (r.m < 60) return r;
    r.m = 0; r.hr = t.hr + 1;
    if (r.hr < 24) return r;
    r.hr = 0; r.w = (t.w + 1) % 7; r.d = t.d + 1;
    if (r.d <= mdays(t.mo, t.y)) return r;
    r.d = 1; r.mo = t.mo + 1;
    if (r.mo <= 12) return r;
    r.mo = 1; r.y = (t.y + 1) % 100;
    return r;
  endfunction

  function automatic int hour_byte(int hr, bit h24);
    if (h24) return hr;
    if (hr == 0) return 12;
    if (hr < 12) return hr;
    if (hr == 12) return 128 + 12;
    return 128 + hr - 12;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [4:0] a, logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic bus_read(logic [4:0] a, output int v);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    @(negedge clk); cs = 0; rd = 0;
    v = rdata;
  endtask

  task automatic load_time(tm_t t, bit h24);
    bus_write(5'h11, h24 ? 8'h04 : 8'h00);
    bus_write(5'd1, 8'(t.s));
    bus_write(5'd2, 8'(t.m));
    bus_write(5'd3, 8'(hour_byte(t.hr, h24)));
    bus_write(5'd4, 8'(t.d));
    bus_write(5'd5, 8'(t.mo));
    bus_write(5'd6, 8'(t.y));
    bus_write(5'd7, 8'(t.w));
    bus_write(5'd0, 8'(t.h));
  endtask

  // run for exactly one 100 Hz strobe, then read all fields
  task automatic tick_check(tm_t t, bit h24, string tag);
    tm_t e;
    int v;
    load_time(t, h24);
    bus_write(5'h11, h24 ? 8'h0C : 8'h08);
    repeat (340) @(negedge clk);
    e = tnext(t);
    bus_read(5'd0, v); chk({tag, " R1 hundredths"}, v, e.h);
    bus_read(5'd1, v); chk({tag, " R1 seconds"}, v, e.s);
    bus_read(5'd2, v); chk({tag, " R1 minutes"}, v, e.m);
    bus_read(5'd3, v); chk({tag, " R5 hours"}, v, hour_byte(e.hr, h24));
    bus_read(5'd4, v); chk({tag, " R13 day"}, v, e.d);
    bus_read(5'd5, v); chk({tag, " R13 month"}, v, e.mo);
    bus_read(5'd6, v); chk({tag, " R4 year"}, v, e.y);
    bus_read(5'd7, v); chk({tag, " R12 weekday"}, v, e.w);
  endtask

  task automatic phase_check(logic [1:0] fs, int hz);
    int n, v;
    n = (hz + 99) / 100;
    bus_write(5'h11, 8'h0C | 8'(fs));
    bus_write(5'd0, 8'd0);
    repeat (n - 1) @(negedge clk);
    bus_read(5'd0, v); chk("R2 R11 before first strobe", v, 0);
    bus_read(5'd0, v); chk("R2 R11 after first strobe", v, 1);
  endtask

  initial begin
    #1_900_000;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, r0;
    tm_t t;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 0;

    // reset state
    bus_read(5'd0, v);    chk("R7 reset hundredths", v, 0);
    bus_read(5'd3, v);    chk("R5 reset hour midnight 12h", v, 8'h0C);
    bus_read(5'd4, v);    chk("R7 reset day", v, 1);
    bus_read(5'd5, v);    chk("R7 reset month", v, 1);
    bus_read(5'h11, v);   chk("R7 reset command", v, 0);

    // stopped clock holds
    bus_write(5'd0, 8'd5);
    repeat (1000) @(negedge clk);
    bus_read(5'd0, v);    chk("R10 stopped hundredths", v, 5);

    // prescaler phase, two selects
    phase_check(2'd0, 32768);
    phase_check(2'd1, 1048576);
    bus_write(5'h11, 8'h1F);
    bus_read(5'h11, v);   chk("R7 command readback", v, 8'h1F);

    // directed calendar corners
    t = '{h:99, s:59, m:59, hr:23, d:28, mo:2, y:24, w:3};  tick_check(t, 1, "R6 leap");
    t = '{h:99, s:59, m:59, hr:23, d:28, mo:2, y:23, w:3};  tick_check(t, 1, "R6 common");
    t = '{h:99, s:59, m:59, hr:23, d:29, mo:2, y:0,  w:1};  tick_check(t, 1, "R6 leap end");
    t = '{h:99, s:59, m:59, hr:23, d:30, mo:4, y:7,  w:2};  tick_check(t, 1, "R13 april");
    t = '{h:99, s:59, m:59, hr:23, d:31, mo:12, y:99, w:6}; tick_check(t, 1, "R4 century");
    t = '{h:99, s:59, m:59, hr:23, d:10, mo:5, y:50, w:4};  tick_check(t, 0, "R5 midnight");
    t = '{h:99, s:59, m:59, hr:11, d:10, mo:5, y:50, w:4};  tick_check(t, 0, "R5 noon");
    t = '{h:12, s:30, m:15, hr:17, d:3, mo:8, y:41, w:0};   tick_check(t, 0, "R5 pm plain");

    // random instants biased to field ends
    for (int i = 0; i < 24; i++) begin
      t.h  = ($urandom % 3 != 0) ? 99 : $urandom_range(0, 99);
      t.s  = ($urandom % 2 == 0) ? 59 : $urandom_range(0, 59);
      t.m  = ($urandom % 2 == 0) ? 59 : $urandom_range(0, 59);
      t.hr = ($urandom % 2 == 0) ? 23 : $urandom_range(0, 23);
      t.mo = $urandom_range(1, 12);
      t.y  = $urandom_range(0, 99);
      t.d  = ($urandom % 2 == 0) ? mdays(t.mo, t.y) : $urandom_range(1, mdays(t.mo, t.y));
      t.w  = $urandom_range(0, 6);
      tick_check(t, 1'($urandom % 2), "R1 random");
    end

    // snapshot isolation
    t = '{h:40, s:21, m:5, hr:9, d:2, mo:3, y:10, w:1};
    load_time(t, 1);
    bus_read(5'd0, v);
    bus_write(5'd1, 8'd17);
    bus_read(5'd1, v);    chk("R3 frozen seconds", v, 21);
    bus_read(5'd0, v);
    bus_read(5'd1, v);    chk("R3 refreshed seconds", v, 17);

    // multiplexed addressing
    bus_write(5'h11, 8'h04);
    @(negedge clk); ale = 1; addr = 5'd2;
    @(negedge clk); ale = 0; addr = 5'h11; cs = 1; wr = 1; wdata = 8'd7;
    @(negedge clk); cs = 0; wr = 0; ale = 1;
    bus_read(5'd0, v);
    bus_read(5'd2, v);    chk("R8 latched write minutes", v, 7);
    bus_read(5'h11, v);   chk("R8 command untouched", v, 8'h04);
    @(negedge clk); ale = 1; addr = 5'h11;
    @(negedge clk); ale = 0; addr = 5'd2; cs = 1; rd = 1;
    @(negedge clk); cs = 0; rd = 0; ale = 1;
    chk("R8 latched read command", rdata, 8'h04);

    // power-down
    bus_write(5'h11, 8'h0C);
    bus_write(5'd1, 8'd10);
    bus_write(5'd0, 8'd0);
    bus_read(5'd0, r0);
    @(negedge clk); pwr_down = 1;
    bus_write(5'd1, 8'd40);
    bus_write(5'h11, 8'h00);
    bus_read(5'd1, v);    chk("R9 read ignored", v, r0);
    repeat (800) @(negedge clk);
    pwr_down = 0;
    bus_read(5'd0, v);    chk("R9 counting continued", (v >= 2) ? 1 : 0, 1);
    bus_read(5'd1, v);    chk("R9 seconds write ignored", v, 10);
    bus_read(5'h11, v);   chk("R9 command write ignored", v, 8'h0C);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule